// File: doc/BRIEF.md
# Ingress Training Synchronisation Monitor

This block observes an already decoded ingress word stream on a packet-over-parallel link. The stream alternates between normal control or data words and training words. The block counts how many valid training words arrive in an unbroken run. When that run reaches a programmable threshold, it raises an out-of-sync flag. A threshold of zero turns this detection off entirely.

The block also keeps a diagnostic tally of the four-bit diagonal-parity errors that an upstream checker reports for incoming control words. The tally is 16 bits wide, stops at its maximum value, and returns to zero whenever it is read. The block does not compute parity, align bit phases or deskew lanes. It only consumes the per-word flags that other logic produces.

Top module: `ingress_sync_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_of_sync` is 0 and `dip_err_count` is 0 after that edge.
- R2: With `train_thresh` = N (1 to 255), `out_of_sync` rises one cycle after the N-th consecutive valid training word. After N-1 such words it is still 0.
- R3: Cycles with `word_vld` = 0 neither advance nor break a training run, and they leave `out_of_sync` unchanged.
- R4: A valid word with `word_is_train` = 0 restarts the run and clears `out_of_sync` on the next cycle.
- R5: While `train_thresh` = 0, `out_of_sync` is 0 from the next cycle on, whatever words arrive.
- R6: A training run much longer than the threshold keeps `out_of_sync` high, with no wrap of the run count, until a valid non-training word arrives.
- R7: Each cycle with `dip_err` = 1 and `cnt_rd` = 0 raises `dip_err_count` by one on the next cycle.
- R8: `dip_err_count` stops at 0xFFFF. Further error strobes leave it at 0xFFFF.
- R9: During a cycle with `cnt_rd` = 1, `dip_err_count` shows the accumulated value. On the next cycle it is 0 if no error strobe came with the read.
- R10: When `dip_err` and `cnt_rd` are both 1 in the same cycle, the read shows the old value and the count becomes 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | A decoded word is present this cycle |
| word_is_train | input | 1 | The present word is a training word |
| dip_err | input | 1 | Parity error reported for a control word |
| train_thresh | input | 8 | Training run length that declares loss of sync; 0 disables |
| cnt_rd | input | 1 | Read strobe for the error count (clear on read) |
| out_of_sync | output | 1 | Loss-of-synchronisation flag, registered |
| dip_err_count | output | 16 | Saturating parity error count, registered |

## Verification
The sync detector is driven with unbroken training runs at thresholds of 1 and 4. This separates an off-by-one in the threshold compare from correct behaviour. Runs broken by idle cycles show that idle cycles are ignored, while runs ended by a non-training word show the restart. A zero threshold and a 300-word burst at threshold 255 exercise the disable path and the run saturation. For the error count, spaced strobes, a read with and without a coincident strobe, and a 65,537-strobe run separate correct accumulation, clear on read, the restart at 1 and saturation from wrap-around.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;
  localparam int unsigned SM_THRESH_W = 8;
  localparam int unsigned SM_ERR_W    = 16;
endpackage

// File: rtl/train_run_tracker.sv
module train_run_tracker #(
  parameter int unsigned TH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            word_vld,
  input  logic            word_is_train,
  input  logic [TH_W-1:0] thresh,
  output logic            oos
);
  localparam logic [TH_W-1:0] ZERO_TH = '0;

  logic [TH_W-1:0] run_q;
  logic [TH_W:0]   run_inc;
  logic            oos_q;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      oos_q <= 1'b0;
    end else if (thresh == ZERO_TH) begin
      run_q <= '0;
      oos_q <= 1'b0;
    end else if (word_vld) begin
      if (!word_is_train) begin
        run_q <= '0;
        oos_q <= 1'b0;
      end else if (run_inc >= {1'b0, thresh}) begin
        run_q <= thresh;
        oos_q <= 1'b1;
      end else begin
        run_q <= run_inc[TH_W-1:0];
      end
    end
  end

  assign oos = oos_q;

  // R1: reset leaves the flag low
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !oos);
  // R4: a valid non-training word clears the flag
  p_break_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !word_is_train) |=> !oos);
  // R5: zero threshold disables detection
  p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (thresh == ZERO_TH) |=> !oos);
  // R3: idle cycles leave the flag untouched
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!word_vld && thresh != ZERO_TH) |=> $stable(oos));
  // R6: run count never exceeds a nonzero threshold
  p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (thresh != ZERO_TH && $stable(thresh)) |-> run_q <= thresh);
endmodule

// File: rtl/sat_clr_counter.sv
module sat_clr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= inc ? CNT_ONE : '0;
    end else if (inc && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

  // R1: reset clears the count
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> count == '0);
  // R7: an unread strobe adds exactly one below the ceiling
  p_step_one_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  // R8: no wrap at the ceiling
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && count == CNT_MAX) |=> count == CNT_MAX);
  // R9: plain read clears
  p_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc) |=> count == '0);
  // R10: read with strobe restarts at one
  p_read_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> count == CNT_ONE);
  // R7: without strobe or read the count holds
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/ingress_sync_monitor.sv
module ingress_sync_monitor
  import sync_mon_pkg::*;
#(
  parameter int unsigned THRESH_W = SM_THRESH_W,
  parameter int unsigned ERR_W    = SM_ERR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                word_vld,
  input  logic                word_is_train,
  input  logic                dip_err,
  input  logic [THRESH_W-1:0] train_thresh,
  input  logic                cnt_rd,
  output logic                out_of_sync,
  output logic [ERR_W-1:0]    dip_err_count
);
  train_run_tracker #(.TH_W(THRESH_W)) u_run (
    .clk           (clk),
    .rst           (rst),
    .word_vld      (word_vld),
    .word_is_train (word_is_train),
    .thresh        (train_thresh),
    .oos           (out_of_sync)
  );

  sat_clr_counter #(.CNT_W(ERR_W)) u_err (
    .clk   (clk),
    .rst   (rst),
    .inc   (dip_err),
    .clr   (cnt_rd),
    .count (dip_err_count)
  );
endmodule

// File: tb/test_ingress_sync_monitor.sv
`timescale 1ns/1ps
module test_ingress_sync_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic        word_is_train = 1'b0;
  logic        dip_err = 1'b0;
  logic [7:0]  train_thresh = 8'd0;
  logic        cnt_rd = 1'b0;
  logic        out_of_sync;
  logic [15:0] dip_err_count;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  ingress_sync_monitor i_ingress_sync_monitor (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_is_train(word_is_train),
    .dip_err(dip_err), .train_thresh(train_thresh), .cnt_rd(cnt_rd),
    .out_of_sync(out_of_sync), .dip_err_count(dip_err_count)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // drive one cycle at the falling edge, sample just after the rising edge
  task automatic step(input logic v, input logic t, input logic e, input logic r);
    @(negedge clk);
    word_vld = v; word_is_train = t; dip_err = e; cnt_rd = r;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) idle();
    check("R1 oos after reset", out_of_sync, 0);
    check("R1 count after reset", dip_err_count, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_threshold_hit();
    train_thresh = 8'd4;
    step(1, 0, 0, 0);
    for (int i = 1; i <= 3; i++) step(1, 1, 0, 0);
    check("R2 after N-1 training words", out_of_sync, 0);
    step(1, 1, 0, 0);
    check("R2 after N training words", out_of_sync, 1);
    train_thresh = 8'd1;
    step(1, 0, 0, 0);
    check("R4 non-training clears", out_of_sync, 0);
    step(1, 1, 0, 0);
    check("R2 threshold 1 single word", out_of_sync, 1);
    step(1, 0, 0, 0);
  endtask

  task automatic t_idle_gaps();
    train_thresh = 8'd3;
    step(1, 0, 0, 0);
    step(1, 1, 0, 0); idle(); idle();
    step(1, 1, 0, 0); idle();
    check("R3 run across idle not yet full", out_of_sync, 0);
    step(1, 1, 0, 0);
    check("R3 idle cycles do not break run", out_of_sync, 1);
    idle(); idle();
    check("R3 idle keeps flag", out_of_sync, 1);
    step(1, 0, 0, 0);
    check("R4 flag cleared by non-training", out_of_sync, 0);
    step(1, 1, 0, 0); step(1, 1, 0, 0);
    check("R4 run restarted after break", out_of_sync, 0);
    step(1, 0, 0, 0);
  endtask

  task automatic t_disabled();
    train_thresh = 8'd2;
    step(1, 1, 0, 0); step(1, 1, 0, 0);
    check("R2 flag set before disable", out_of_sync, 1);
    train_thresh = 8'd0;
    step(1, 1, 0, 0);
    check("R5 zero threshold clears flag", out_of_sync, 0);
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0);
    check("R5 zero threshold never asserts", out_of_sync, 0);
    step(1, 0, 0, 0);
  endtask

  task automatic t_long_burst();
    train_thresh = 8'd255;
    step(1, 0, 0, 0);
    for (int i = 1; i <= 254; i++) step(1, 1, 0, 0);
    check("R2 254 of 255", out_of_sync, 0);
    step(1, 1, 0, 0);
    check("R2 255 of 255", out_of_sync, 1);
    for (int i = 0; i < 45; i++) step(1, 1, 0, 0);
    check("R6 long burst holds flag", out_of_sync, 1);
    step(1, 0, 0, 0);
    check("R6 burst ended by non-training", out_of_sync, 0);
  endtask

  task automatic t_err_count();
    step(0, 0, 0, 1);
    check("R9 clear before count", dip_err_count, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 0); idle();
    end
    check("R7 five strobes", dip_err_count, 5);
    @(negedge clk); cnt_rd = 1'b1;
    #1 check("R9 read shows value", dip_err_count, 5);
    @(posedge clk); #1;
    check("R9 read clears", dip_err_count, 0);
    idle();
  endtask

  task automatic t_read_with_err();
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0);
    @(negedge clk); cnt_rd = 1'b1; dip_err = 1'b1;
    #1 check("R10 read shows old value", dip_err_count, 3);
    @(posedge clk); #1;
    check("R10 restart at one", dip_err_count, 1);
    idle();
    check("R10 value held after", dip_err_count, 1);
  endtask

  task automatic t_saturate();
    step(0, 0, 0, 1);
    for (int i = 0; i < 65534; i++) step(0, 0, 1, 0);
    check("R7 count below ceiling", dip_err_count, 65534);
    step(0, 0, 1, 0);
    check("R8 reaches ceiling", dip_err_count, 65535);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    check("R8 no wrap", dip_err_count, 65535);
    step(0, 0, 0, 1);
    check("R9 clear from ceiling", dip_err_count, 0);
  endtask

  initial begin
    t_reset();
    t_threshold_hit();
    t_idle_gaps();
    t_disabled();
    t_long_burst();
    t_err_count();
    t_read_with_err();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule